// File: doc/BRIEF.md
# Synthesizer Serial Loader

This block programs an external frequency synthesizer over a three-wire serial link made of data, clock and latch-enable lines. When the receiver switches from off to on and the synthesizer-control enable input is set, the block copies two parallel frequency words into internal registers. It shifts word A and then word B out MSB first. After each word it pulses latch enable, which moves the shifted bits into the synthesizer's divider registers. An oscillator enable output stays high for the whole transfer.

All timing counts cycles of a base `tick` enable. Each word may hold up to 24 bits. A per-word length input selects how many of the low-order bits are sent, and the unused high-order positions are skipped. The bit stream is not uniform. The clock low phase of the 13th transmitted bit of each word is stretched by a pause `tp`, and the same pause is added to the delay before word B. The receive bit-rate code selects `tp`.

The state machine has six states:
- `ST_IDLE`: waiting for a start.
- `ST_CLK_LO`: clock low, data valid.
- `ST_CLK_HI`: clock high.
- `ST_LATCH`: latch pulse.
- `ST_GAP`: delay between the two words.
- `ST_DONE`: one-cycle completion.

Its transitions are:
- IDLE→CLK_LO on a qualified start.
- CLK_LO→CLK_HI when the low phase expires.
- CLK_HI→CLK_LO while bits remain in the word.
- CLK_HI→LATCH after the last bit of the word.
- LATCH→GAP after word A.
- LATCH→DONE after word B.
- GAP→CLK_LO, which loads word B.
- DONE→IDLE.

Top module: `synth_loader`

## Requirements
- R1: A synchronous reset forces `ser_data`, `ser_clk`, `ser_le`, `osc_en`, `busy` and `done` low and returns the sequencer to idle.
- R2: A transfer starts only on a 0→1 change of `rx_on` seen while `cfg_en` is 1. With `cfg_en` at 0 nothing starts. Holding `rx_on` high never restarts a transfer. After reset, `rx_on` must first be seen low before a start is possible.
- R3: Word A is sent before word B, each MSB first. The receiver samples `ser_data` on each rising edge of `ser_clk`.
- R4: Only the low `len` bits of a word are sent. A length of 0 or above 24 means all 24 bits.
- R5: `ser_data` never changes while `ser_clk` is high. It changes only together with a falling clock edge, or while the clock is low.
- R6: After the last bit of each word, exactly one `ser_le` pulse of LE_TICKS ticks is issued with `ser_clk` low.
- R7: Each clock high phase lasts HI_TICKS ticks. Each clock low phase lasts LO_TICKS ticks, except for the cases in R8 and R10.
- R8: The low phase of the 13th transmitted bit of a word lasts LO_TICKS+tp ticks. A word shorter than 13 bits has no such pause.
- R9: `rate` selects tp: code 0 gives 119 ticks, code 1 gives 33 ticks, and codes 2 and 3 give 1 tick.
- R10: From the end of the first latch pulse to the first rising clock edge of word B there are GAP_TICKS+tp+LO_TICKS ticks.
- R11: `osc_en` is high from the start of a transfer through the last latch pulse, and low when idle.
- R12: `busy` is high during a transfer. At its end, `done` pulses for exactly one cycle while `busy` is low.
- R13: Start requests that arrive during a transfer are ignored. Each transfer yields exactly two latch pulses and one `done`.
- R14: All phase timing advances only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Base timing enable |
| rx_on | input | 1 | Receiver on/off status |
| cfg_en | input | 1 | Synthesizer-control enable |
| rate | input | 2 | Receive bit-rate code (0 slow, 1 mid, 2/3 fast) |
| word_a | input | 24 | First frequency word |
| word_b | input | 24 | Second frequency word |
| len_a | input | 5 | Used bit count of word A |
| len_b | input | 5 | Used bit count of word B |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Serial clock |
| ser_le | output | 1 | Latch enable |
| osc_en | output | 1 | Oscillator enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A bit position that is off by one shows up as a shifted or truncated word. A missed pause shows as a 13th-bit low time short by exactly tp ticks at the 13th rising clock edge. A lost word select shows up at the second latch pulse, as a wrong word B or a missing latch pulse. A start detector that misfires shows as busy rising with no qualifying `rx_on` edge, or as a second `done`, within a few cycles of the stray request. The checks therefore measure every phase length on the serial pins in ticks and rebuild both words from the clock edges.

// File: rtl/synth_pkg.sv
package synth_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_LATCH,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RATE_SLOW     = 2'd0,
        RATE_MID      = 2'd1,
        RATE_FAST     = 2'd2,
        RATE_FAST_ALT = 2'd3
    } rate_t;

endpackage

// File: rtl/synth_rise_det.sv
module synth_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Reset treats the level as already high, so a real low phase is needed first.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/synth_pause_sel.sv
module synth_pause_sel import synth_pkg::*; #(
    parameter int CW         = 8,
    parameter int PAUSE_SLOW = 119,
    parameter int PAUSE_MID  = 33,
    parameter int PAUSE_FAST = 1
) (
    input  logic [1:0]    rate,
    output logic [CW-1:0] pause
);
    always_comb begin
        unique case (rate_t'(rate))
            RATE_SLOW: pause = CW'(PAUSE_SLOW);
            RATE_MID:  pause = CW'(PAUSE_MID);
            default:   pause = CW'(PAUSE_FAST);
        endcase
    end
endmodule

// File: rtl/synth_phase_timer.sv
module synth_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    input  logic [CW-1:0] len,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = tick && !clr && (cnt_q == len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr || expire) cnt_q <= '0;
        else if (tick)            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/synth_loader.sv
module synth_loader import synth_pkg::*; #(
    parameter int WORD_W     = 24,
    parameter int LO_TICKS   = 2,
    parameter int HI_TICKS   = 2,
    parameter int LE_TICKS   = 2,
    parameter int GAP_TICKS  = 3,
    parameter int PAUSE_BIT  = 13,
    parameter int PAUSE_SLOW = 119,
    parameter int PAUSE_MID  = 33,
    parameter int PAUSE_FAST = 1,
    localparam int LW        = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_on,
    input  logic              cfg_en,
    input  logic [1:0]        rate,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic [LW-1:0]     len_a,
    input  logic [LW-1:0]     len_b,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_le,
    output logic              osc_en,
    output logic              busy,
    output logic              done
);
    localparam int CW = $clog2(PAUSE_SLOW + LO_TICKS + HI_TICKS + LE_TICKS + GAP_TICKS + 1) + 1;

    function automatic logic [LW-1:0] used_len(input logic [LW-1:0] l);
        if (l == '0 || int'(l) > WORD_W) return LW'(WORD_W);
        return l;
    endfunction

    seq_state_t        state_q, state_d;
    logic              rx_rise, start, expire, tmr_clr;
    logic [CW-1:0]     pause_now, pause_q, phase_len;
    logic [WORD_W-1:0] wa_q, wb_q;
    logic [LW-1:0]     lb_q, pos_q, sent_q;
    logic              wsel_q;

    synth_rise_det u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (rx_on),
        .rise  (rx_rise)
    );

    synth_pause_sel #(
        .CW         (CW),
        .PAUSE_SLOW (PAUSE_SLOW),
        .PAUSE_MID  (PAUSE_MID),
        .PAUSE_FAST (PAUSE_FAST)
    ) u_pause (
        .rate  (rate),
        .pause (pause_now)
    );

    synth_phase_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .clr    (tmr_clr),
        .len    (phase_len),
        .expire (expire)
    );

    assign start   = rx_rise && cfg_en && (state_q == ST_IDLE);
    assign tmr_clr = (state_q == ST_IDLE) || (state_q == ST_DONE);

    // Length of the phase being timed, in ticks
    always_comb begin
        unique case (state_q)
            ST_CLK_LO: phase_len = CW'(LO_TICKS)
                                 + ((sent_q == LW'(PAUSE_BIT - 1)) ? pause_q : '0);
            ST_CLK_HI: phase_len = CW'(HI_TICKS);
            ST_LATCH:  phase_len = CW'(LE_TICKS);
            ST_GAP:    phase_len = CW'(GAP_TICKS) + pause_q;
            default:   phase_len = CW'(1);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)  state_d = ST_CLK_LO;
            ST_CLK_LO: if (expire) state_d = ST_CLK_HI;
            ST_CLK_HI: if (expire) state_d = (pos_q == '0) ? ST_LATCH : ST_CLK_LO;
            ST_LATCH:  if (expire) state_d = wsel_q ? ST_DONE : ST_GAP;
            ST_GAP:    if (expire) state_d = ST_CLK_LO;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Word shadows, bit position and word select
    always_ff @(posedge clk) begin
        if (rst) begin
            wa_q    <= '0;
            wb_q    <= '0;
            lb_q    <= '0;
            pos_q   <= '0;
            sent_q  <= '0;
            wsel_q  <= 1'b0;
            pause_q <= '0;
        end else if (start) begin
            wa_q    <= word_a;
            wb_q    <= word_b;
            lb_q    <= used_len(len_b);
            pos_q   <= used_len(len_a) - LW'(1);
            sent_q  <= '0;
            wsel_q  <= 1'b0;
            pause_q <= pause_now;
        end else if (expire) begin
            unique case (state_q)
                ST_CLK_HI: if (pos_q != '0) begin
                    pos_q  <= pos_q - LW'(1);
                    sent_q <= sent_q + LW'(1);
                end
                ST_GAP: begin
                    wsel_q <= 1'b1;
                    pos_q  <= lb_q - LW'(1);
                    sent_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        ser_clk  = 1'b0;
        ser_le   = 1'b0;
        ser_data = 1'b0;
        osc_en   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_CLK_LO, ST_CLK_HI: begin
                ser_clk  = (state_q == ST_CLK_HI);
                ser_data = wsel_q ? wb_q[pos_q] : wa_q[pos_q];
                osc_en   = 1'b1;
                busy     = 1'b1;
            end
            ST_LATCH: begin
                ser_le = 1'b1;
                osc_en = 1'b1;
                busy   = 1'b1;
            end
            ST_GAP: begin
                osc_en = 1'b1;
                busy   = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk (
    input logic clk,
    input logic rst,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_le,
    input logic osc_en,
    input logic busy,
    input logic done
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !ser_clk && !ser_le && !ser_data && !osc_en && !busy && !done);

    assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
        ser_clk && $past(ser_clk) |-> $stable(ser_data));

    assert_latch_clock_low_R6: assert property (@(posedge clk) disable iff (rst)
        ser_le |-> !ser_clk);

    assert_osc_cover_R11: assert property (@(posedge clk) disable iff (rst)
        (ser_clk || ser_le) |-> osc_en);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_clk && !ser_le && !ser_data && !osc_en);

    assert_done_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
endmodule

bind synth_loader synth_loader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_le   (ser_le),
    .osc_en   (osc_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/synth_loader_tb.sv
module synth_loader_tb;
    localparam int LO = 2, HI = 2, LE = 2, GP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic rx_on = 1'b0;
    logic cfg_en = 1'b1;
    logic [1:0] rate = 2'd0;
    logic [23:0] word_a = '0, word_b = '0;
    logic [4:0] len_a = 5'd24, len_b = 5'd24;
    logic ser_data, ser_clk, ser_le, osc_en, busy, done;

    always #4 clk = ~clk; // 125 MHz

    synth_loader u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rx_on(rx_on), .cfg_en(cfg_en),
        .rate(rate), .word_a(word_a), .word_b(word_b), .len_a(len_a), .len_b(len_b),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
        .osc_en(osc_en), .busy(busy), .done(done)
    );

    // {rate, len_a, len_b, word_a, word_b, tick divider}
    localparam logic [61:0] VEC [6] = '{
        {2'd0, 5'd24, 5'd24, 24'hA5C3F0, 24'h0F1E2D, 2'd1},
        {2'd1, 5'd20, 5'd16, 24'hFFFFFF, 24'h123456, 2'd1},
        {2'd2, 5'd12, 5'd13, 24'hABCDEF, 24'h13579B, 2'd1},
        {2'd3, 5'd0,  5'd30, 24'h800001, 24'h7FFFFE, 2'd1},
        {2'd1, 5'd1,  5'd24, 24'h000001, 24'hC00003, 2'd2},
        {2'd0, 5'd13, 5'd5,  24'h001FFF, 24'h0000AA, 2'd1}
    };

    int n_chk = 0, n_err = 0;
    int cyc = 0, tdiv = 1;

    // monitor state
    logic [23:0] cur, cap_w [0:3];
    int ncur, cap_n [0:3], low13 [0:3], widx, lowcnt, hicnt, lerun;
    int gap, bad_low, bad_hi, bad_le, le_cnt, done_cnt, busy_cnt;
    logic prev_clk = 1'b0, prev_le = 1'b0;

    task automatic clear_mon();
        cur = '0; ncur = 0; widx = 0; lowcnt = 0; hicnt = 0; lerun = 0;
        gap = 0; bad_low = 0; bad_hi = 0; bad_le = 0; le_cnt = 0; done_cnt = 0; busy_cnt = 0;
        for (int k = 0; k < 4; k++) begin cap_w[k] = '0; cap_n[k] = 0; low13[k] = 0; end
    endtask

    always @(negedge clk) begin
        cyc++;
        tick <= ((cyc % tdiv) == 0);
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
        if (!rst) begin
            if (done) done_cnt++;
            if (busy) busy_cnt++;
            if (ser_le) lerun++;
            if (!ser_le && prev_le) begin
                if (lerun != LE * tdiv) bad_le++;
                lerun = 0;
            end
            if (ser_le && !prev_le) begin
                if (widx < 4) begin cap_w[widx] = cur; cap_n[widx] = ncur; end
                widx++; cur = '0; ncur = 0; lowcnt = 0; le_cnt++;
            end
            if (busy && !ser_clk && !ser_le) lowcnt++;
            if (ser_clk) hicnt++;
            if (!ser_clk && prev_clk) begin
                if (hicnt != HI * tdiv) bad_hi++;
                hicnt = 0;
            end
            if (ser_clk && !prev_clk) begin
                if (ncur == 12 && widx < 4) low13[widx] = lowcnt;
                else if (ncur == 0) begin if (widx == 1) gap = lowcnt; end
                else if (lowcnt != LO * tdiv) bad_low++;
                cur = {cur[22:0], ser_data};
                ncur++; lowcnt = 0;
            end
            prev_clk = ser_clk; prev_le = ser_le;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int tp_of(input logic [1:0] r);
        return (r == 2'd0) ? 119 : (r == 2'd1) ? 33 : 1;
    endfunction

    function automatic int eff(input logic [4:0] l);
        return (l == 0 || l > 24) ? 24 : int'(l);
    endfunction

    function automatic logic [23:0] emask(input logic [23:0] w, input logic [4:0] l);
        logic [24:0] m = (25'd1 << eff(l)) - 25'd1;
        return w & m[23:0];
    endfunction

    task automatic wait_done(input int lim);
        for (int k = 0; k < lim && done_cnt == 0; k++) @(negedge clk);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ser_clk && !ser_le && !ser_data && !osc_en && !busy && !done,
            "R1", "outputs in reset", {ser_clk, ser_le, ser_data, osc_en, busy, done}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Vector table: R3 R4 R6 R7 R8 R9 R10 R14
        for (int i = 0; i < 6; i++) begin
            logic [61:0] v = VEC[i];
            rate = v[61:60]; len_a = v[59:55]; len_b = v[54:50];
            word_a = v[49:26]; word_b = v[25:2]; tdiv = int'(v[1:0]);
            rx_on = 1'b0;
            repeat (4) @(negedge clk);
            clear_mon();
            rx_on = 1'b1;
            wait_done(6000);
            repeat (30) @(negedge clk); // R2: rx_on held high, no restart
            chk(cap_w[0] == emask(word_a, len_a), "R3", "word A", cap_w[0], emask(word_a, len_a));
            chk(cap_w[1] == emask(word_b, len_b), "R3", "word B", cap_w[1], emask(word_b, len_b));
            chk(cap_n[0] == eff(len_a), "R4", "bits A", cap_n[0], eff(len_a));
            chk(cap_n[1] == eff(len_b), "R4", "bits B", cap_n[1], eff(len_b));
            chk(low13[0] == ((eff(len_a) >= 13) ? (LO + tp_of(rate)) * tdiv : 0),
                "R8", "13th low A", low13[0], (eff(len_a) >= 13) ? (LO + tp_of(rate)) * tdiv : 0);
            chk(low13[1] == ((eff(len_b) >= 13) ? (LO + tp_of(rate)) * tdiv : 0),
                "R9", "13th low B", low13[1], (eff(len_b) >= 13) ? (LO + tp_of(rate)) * tdiv : 0);
            chk(gap == (GP + tp_of(rate) + LO) * tdiv, "R10", "gap", gap, (GP + tp_of(rate) + LO) * tdiv);
            chk(bad_low == 0 && bad_hi == 0, "R7", "phase errors", bad_low + bad_hi, 0);
            chk(bad_le == 0 && le_cnt == 2, "R6", "latch pulses", le_cnt, 2);
            chk(done_cnt == 1, "R2", "done count", done_cnt, 1);
            if (tdiv != 1) chk(bad_low == 0, "R14", "tick-scaled low", bad_low, 0);
        end
        tdiv = 1;

        // R2: cfg_en low blocks start
        cfg_en = 1'b0; rx_on = 1'b0;
        repeat (4) @(negedge clk);
        clear_mon();
        rx_on = 1'b1;
        repeat (60) @(negedge clk);
        chk(busy_cnt == 0 && le_cnt == 0, "R2", "start with cfg_en low", busy_cnt, 0);
        cfg_en = 1'b1;

        // R13: start requests during transfer ignored
        rate = 2'd1; len_a = 5'd24; len_b = 5'd24; word_a = 24'h5A5A5A; word_b = 24'h3C3C3C;
        rx_on = 1'b0;
        repeat (4) @(negedge clk);
        clear_mon();
        rx_on = 1'b1;
        repeat (10) @(negedge clk);
        // R11: oscillator enable during transfer
        chk(osc_en && busy, "R11", "osc_en mid transfer", osc_en, 1);
        for (int k = 0; k < 4; k++) begin
            rx_on = 1'b0; repeat (3) @(negedge clk);
            rx_on = 1'b1; repeat (5) @(negedge clk);
        end
        wait_done(6000);
        repeat (2) @(negedge clk);
        // R12: busy low after done
        chk(!busy && !osc_en, "R12", "busy after done", busy, 0);
        repeat (150) @(negedge clk);
        chk(done_cnt == 1 && le_cnt == 2, "R13", "transfers", done_cnt, 1);
        chk(cap_w[0] == 24'h5A5A5A && cap_w[1] == 24'h3C3C3C, "R13", "words", cap_w[0], 24'h5A5A5A);

        // R1: reset mid-transfer, R2: no start after reset with rx_on high
        rx_on = 1'b0;
        repeat (4) @(negedge clk);
        rx_on = 1'b1;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!ser_clk && !ser_le && !ser_data && !osc_en && !busy && !done,
            "R1", "outputs after mid reset", {ser_clk, ser_le, ser_data, osc_en, busy, done}, 0);
        rst = 1'b0;
        clear_mon();
        repeat (60) @(negedge clk);
        chk(busy_cnt == 0, "R2", "start after reset with rx_on high", busy_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule